// File: doc/BRIEF.md
# Serial-Addressed Control Latch Bank

This block takes short control words from a slow three-wire serial port (serial clock, serial data, strobe) and uses each one to set or clear a single bit in a bank of addressable control latches. The latch outputs drive switch enables and mode selects elsewhere on the chip. The serial pins are not timed to the system clock. Each pin passes through a synchroniser, and edges are detected in the system clock domain. For this reason the system clock must run at least eight times faster than the fastest serial clock.

A host shifts in a 7-bit word: six address bits, then one data bit. It then pulses the strobe. On the strobe's rising edge the addressed latch takes the data bit. Address zero is reserved as a clear-all command. Only addresses 1 to `NumChan` hold state. Every other position of the output vector reads as zero.

Top module: `serial_latch_bank`

## Requirements
- R1: A word is `AddrW`+1 bits sent first-bit-most-significant. After 7 shifts the first six bits form the address (first bit = address bit 5) and the last bit is the data bit.
- R2: Each synchronised rising edge of the serial clock shifts the synchronised data pin into the low end of the shift register. While the strobe stays low, no latch output changes, however many bits are shifted.
- R3: On a synchronised strobe rising edge with an address in 1..`NumChan`, latch output bit [address] takes the data bit (1 sets, 0 clears). All other outputs keep their values.
- R4: On a strobe rising edge with address 0, every latch output becomes 0, whatever the data bit is.
- R5: While reset is low, and on the first cycle after it, every latch output is 0.
- R6: A strobe with an address above `NumChan` changes no output. Output bit 0 and bits above `NumChan` are always 0.
- R7: When strobe and serial clock rising edges are detected in the same system cycle, the update uses the shift register contents from before that cycle's shift.
- R8: A latch output changes on the third system clock rising edge after the strobe pin goes high (two synchroniser stages plus edge detection, with default `SyncDepth`=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rstN | input | 1 | Active-low reset; clears all latches |
| serClk | input | 1 | Serial clock; shifts on its rising edge |
| serData | input | 1 | Serial data, first bit most significant |
| serStrobe | input | 1 | Strobe; its rising edge applies the shifted word |
| latchOut | output | 2**AddrW | Latch outputs, indexed by address |

## Verification
The bench builds the block with its default parameters: six address bits, 48 channels and a two-stage synchroniser. These defaults give a 64-wide output vector. It therefore contains both the reserved position 0 and fifteen unimplemented addresses (49 to 63) that writes can reach. The two-stage depth fixes the three-edge strobe latency that the bench measures cycle by cycle. A behavioural model with a pin-history queue is compared against the outputs on every clock. The model covers set, clear, clear-all, ignored addresses, shifting without a strobe, and a strobe edge that coincides with a serial clock edge.

// File: rtl/serlatch_pkg.sv
package serlatch_pkg;
  typedef struct packed {
    logic shiftEn;
    logic update;
    logic serBit;
  } ctrl_strobe_t;
endpackage

// File: rtl/serlatch_ctrl.sv
module serlatch_ctrl
  import serlatch_pkg::*;
#(
  parameter int SyncDepth = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serData,
  input  logic         serStrobe,
  output ctrl_strobe_t strb
);
  localparam int Top = SyncDepth - 1;

  logic [SyncDepth-1:0] clkSync, datSync, stbSync;
  logic clkPrev, stbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      datSync <= '0;
      stbSync <= '0;
      clkPrev <= 1'b0;
      stbPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SyncDepth-2:0], serClk};
      datSync <= {datSync[SyncDepth-2:0], serData};
      stbSync <= {stbSync[SyncDepth-2:0], serStrobe};
      clkPrev <= clkSync[Top];
      stbPrev <= stbSync[Top];
    end
  end

  assign strb.shiftEn = clkSync[Top] & ~clkPrev;
  assign strb.update  = stbSync[Top] & ~stbPrev;
  assign strb.serBit  = datSync[Top];

  // R8: an update request lasts exactly one system cycle per strobe edge
  a_r8_update_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.update |=> !strb.update);

  // R2: one shift per serial clock edge
  a_r2_shift_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn);
endmodule

// File: rtl/serlatch_datapath.sv
module serlatch_datapath
  import serlatch_pkg::*;
#(
  parameter int AddrW   = 6,
  parameter int NumChan = 48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strb,
  output logic [(1<<AddrW)-1:0] latchOut
);
  localparam int WordW = AddrW + 1;
  localparam int NumPos = 1 << AddrW;
  localparam logic [AddrW-1:0] LastAddr = AddrW'(NumChan);

  logic [WordW-1:0] shiftQ;
  logic [AddrW-1:0] addrField;
  logic dataField, clearAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else if (strb.shiftEn) shiftQ <= {shiftQ[WordW-2:0], strb.serBit};
  end

  assign addrField = shiftQ[WordW-1:1];
  assign dataField = shiftQ[0];
  assign clearAll  = strb.update && (addrField == '0);

  for (genvar i = 0; i < NumPos; i++) begin : g_latch
    if (i >= 1 && i <= NumChan) begin : g_live
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else if (clearAll) bitQ <= 1'b0;
        else if (strb.update && addrField == AddrW'(i)) bitQ <= dataField;
      end
      assign latchOut[i] = bitQ;
    end else begin : g_tied
      assign latchOut[i] = 1'b0;
    end
  end

  // R2: no strobe edge means the latch bank holds
  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !strb.update |=> $stable(latchOut));

  // R3: addressed latch takes the data bit
  a_r3_addressed_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && addrField != '0 && addrField <= LastAddr)
    |=> latchOut[$past(addrField)] == $past(dataField));

  // R3: other latches are untouched
  a_r3_others_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && addrField != '0 && addrField <= LastAddr)
    |=> ((latchOut ^ $past(latchOut)) & ~(NumPos'(1) << $past(addrField))) == '0);

  // R4: clear-all command
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> latchOut == '0);

  // R6: out-of-range writes ignored, unused positions stay zero
  a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && addrField > LastAddr) |=> $stable(latchOut));
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    !latchOut[0] && ((latchOut >> (NumChan + 1)) == '0));

  // R5: bank is clear when reset is released
  a_r5_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> latchOut == '0);
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
  import serlatch_pkg::*;
#(
  parameter int AddrW     = 6,
  parameter int NumChan   = 48,
  parameter int SyncDepth = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serClk,
  input  logic                  serData,
  input  logic                  serStrobe,
  output logic [(1<<AddrW)-1:0] latchOut
);
  ctrl_strobe_t strb;

  serlatch_ctrl #(.SyncDepth(SyncDepth)) i_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serStrobe(serStrobe), .strb(strb)
  );

  serlatch_datapath #(.AddrW(AddrW), .NumChan(NumChan)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .latchOut(latchOut)
  );
endmodule

// File: tb/test_serial_latch_bank.sv
module test_serial_latch_bank;
  localparam time ClkPeriod = 10ns;
  localparam int NumChan = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serStrobe = 1'b0;
  logic [63:0] latchOut;

  int checks = 0;
  int fails = 0;
  logic [63:0] expVec = '0;

  serial_latch_bank i_serial_latch_bank (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serStrobe(serStrobe), .latchOut(latchOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  // Behavioural reference: pin history queue, integer shift register
  logic [2:0] hist [4];
  int unsigned mShift;
  logic [63:0] mLatch;
  initial begin
    for (int k = 0; k < 4; k++) hist[k] = '0;
    mShift = 0;
    mLatch = '0;
  end

  always @(posedge clk) begin
    logic [2:0] cur, prv;
    int unsigned a;
    if (!rstN) begin
      for (int k = 0; k < 4; k++) hist[k] = '0;
      mShift = 0;
      mLatch = '0;
    end else begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = {serClk, serData, serStrobe};
      cur = hist[2];
      prv = hist[3];
      if (cur[0] && !prv[0]) begin
        a = (mShift >> 1) & 63;
        if (a == 0) mLatch = '0;
        else if (a <= NumChan) mLatch[a] = mShift[0];
      end
      if (cur[2] && !prv[2]) mShift = ((mShift << 1) | cur[1]) & 127;
    end
  end

  // Per-cycle comparison against the model (R3, R4, R6, R7, R8)
  always @(negedge clk) begin
    checks++;
    if (latchOut !== mLatch) begin
      fails++;
      $display("FAIL R3 model compare at %0t: actual %h expected %h", $time, latchOut, mLatch);
    end
  end

  task automatic chk(string req, logic [63:0] exp);
    checks++;
    if (latchOut !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, latchOut, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(logic b);
    serData = b; cyc(4);
    serClk = 1'b1; cyc(8);
    serClk = 1'b0; cyc(4);
  endtask

  task automatic shiftWord(logic [5:0] addr, logic d);
    for (int i = 5; i >= 0; i--) shiftBit(addr[i]);
    shiftBit(d);
  endtask

  task automatic pulseStrobe();
    serStrobe = 1'b1; cyc(8);
    serStrobe = 1'b0; cyc(8);
  endtask

  task automatic sendWord(logic [5:0] addr, logic d);
    shiftWord(addr, d);
    pulseStrobe();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    cyc(5);
    chk("R5 during reset", '0);
    rstN = 1'b1;
    cyc(1);
    chk("R5 after reset", '0);

    // R1, R3: set single addresses
    sendWord(6'h07, 1'b1); expVec[7] = 1'b1;
    chk("R1 R3 set 0x07", expVec);
    sendWord(6'h0F, 1'b1); expVec[15] = 1'b1;
    sendWord(6'h30, 1'b1); expVec[48] = 1'b1;
    chk("R3 set 0x0F and 0x30", expVec);
    sendWord(6'h07, 1'b0); expVec[7] = 1'b0;
    chk("R3 clear 0x07", expVec);

    // R2: shifting without strobe leaves outputs alone
    shiftWord(6'h20, 1'b1);
    cyc(10);
    chk("R2 shift without strobe", expVec);
    pulseStrobe(); expVec[32] = 1'b1;
    chk("R2 strobe applies shifted word", expVec);

    // R6: addresses above NumChan ignored
    sendWord(6'h31, 1'b1);
    chk("R6 address 0x31 ignored", expVec);
    sendWord(6'h3F, 1'b1);
    chk("R6 address 0x3F ignored", expVec);

    // R4: clear-all with data bit 1
    sendWord(6'h00, 1'b1); expVec = '0;
    chk("R4 clear all", expVec);

    // R7: strobe edge coincides with serial clock edge
    shiftWord(6'h05, 1'b1);
    serData = 1'b0; cyc(4);
    serClk = 1'b1; serStrobe = 1'b1; cyc(8);
    serClk = 1'b0; serStrobe = 1'b0; cyc(8);
    expVec[5] = 1'b1;
    chk("R7 update uses pre-shift word", expVec);

    // R8: latency of three system edges
    shiftWord(6'h0A, 1'b1);
    serStrobe = 1'b1;
    cyc(2);
    chk("R8 not yet after two edges", expVec);
    cyc(1); expVec[10] = 1'b1;
    chk("R8 updated on third edge", expVec);
    serStrobe = 1'b0; cyc(8);

    // R5: reset mid-run clears
    rstN = 1'b0; cyc(2);
    chk("R5 mid-run reset", '0);
    rstN = 1'b1; cyc(4);
    chk("R5 released", '0);

    finishRun();
  end
endmodule